// File: doc/BRIEF.md
# Four-channel interval timer

This peripheral hangs off a simple 32-bit register bus and offers four independent down-counting timers. Each channel has a control word, a reload word and a read-only count word. The channels share three global words: run enable, interrupt enable and interrupt status. In each of these words a channel owns a four-bit slot, and only the lowest bit of the slot is implemented. That bit is bit 4·n for channel n, so the live bits are 0, 4, 8 and 12.

Once enabled, a channel loads its reload value and steps down on every count tick. When it has reached zero, the next tick reloads it and raises the channel's status flag. A full period is therefore reload + 1 ticks, and software gets the elapsed count as (reload + 1) − count. A channel either counts on every bus clock or only on the clocks where the shared tick-enable input is high. Status flags are cleared by writing ones. A single registered interrupt line reports any flag whose enable bit is set.

Top module: `pit_timer`

## Requirements
- R1: Byte addresses are fixed as follows. 0x00 reads the constant 0x7130_0102. 0x10 reads the channel count, which is 4. 0x14 is interrupt enable, 0x18 is interrupt status and 0x1C is run enable. Channel n has control at 0x20+16·n, reload at 0x24+16·n and count at 0x28+16·n.
- R2: After reset every enable and status bit is zero, all control, reload and count words read zero, and irq_o is low.
- R3: In the run-enable, interrupt-enable and status words only bit 4·n of each channel is implemented. All other bits read zero and ignore writes.
- R4: An enabled channel counts down one step per tick and needs reload + 1 ticks from enable to its first expiry. On the tick where it reads zero it reloads.
- R5: Expiry sets the channel's status bit whether or not its interrupt is enabled.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it as it was.
- R7: irq_o is a register. It rises on the clock after some status bit meets a set enable bit, and it falls on the clock after no such pair remains.
- R8: Clearing a run-enable bit freezes that channel's count. Setting the bit again loads the count from the reload word.
- R9: A write to the reload word leaves the period in progress unchanged and is used at the next reload.
- R10: Control bit 3 = 1 makes a channel count on every clock. Control bit 3 = 0 makes it count only on clocks where tick_en_i is high.
- R11: Control bit 0 selects 32-bit timer mode. While it is 0 the channel holds its count and never expires.
- R12: The count word is read-only. Unmapped addresses read zero and ignore writes.
- R13: When an expiry and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_en_i | input | 1 | Count tick for channels set to the tick source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is R13, an expiry that lands on the same clock as a status clear. The bench starts a channel with a small reload, counts clock edges from the enable write, and times the clearing write so that its edge is exactly the expiry edge. It then reads back a flag that must still be set. A second timing-critical case rewrites a reload word in the middle of a period. The bench samples the count one edge before and one edge at the old expiry to show that the period in progress was kept. For the tick-source vectors, the bench drives tick_en_i itself on every edge, so each expiry edge is known in advance.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int unsigned SLOT_W     = 4;
  localparam int unsigned A_ID       = 'h00;
  localparam int unsigned A_CFG      = 'h10;
  localparam int unsigned A_IE       = 'h14;
  localparam int unsigned A_STA      = 'h18;
  localparam int unsigned A_EN       = 'h1C;
  localparam int unsigned A_CH_BASE  = 'h20;
  localparam int unsigned CH_STRIDE  = 'h10;
  localparam int unsigned OFF_CTRL   = 'h0;
  localparam int unsigned OFF_RELD   = 'h4;
  localparam int unsigned OFF_CNT    = 'h8;
  localparam int unsigned CTRL_MODE  = 0;
  localparam int unsigned CTRL_SRC   = 3;
  localparam logic [31:0] ID_VALUE   = 32'h7130_0102;
endpackage

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              reld_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              tick_en_i,
  output logic [3:0]        ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);
  logic             mode_q, src_q, run;
  logic [CNT_W-1:0] reld_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      src_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      mode_q <= wdata_i[CTRL_MODE];
      src_q  <= wdata_i[CTRL_SRC];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reld_q <= '0;
    else if (reld_we_i) reld_q <= wdata_i[CNT_W-1:0];
  end

  // bus-clock source ignores the tick input; the enable edge only loads
  assign run      = en_i & mode_q & (src_q | tick_en_i) & ~start_i;
  assign expire_o = run & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= reld_q;
    else if (expire_o) cnt_q <= reld_q;
    else if (run)      cnt_q <= cnt_q - 1'b1;
  end

  assign ctrl_o   = {src_q, 2'b00, mode_q};
  assign reload_o = reld_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/pit_glb_regs.sv
`timescale 1ns/1ps
module pit_glb_regs #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ie_we_i,
  input  logic              sta_we_i,
  input  logic              en_we_i,
  input  logic [NUM_CH-1:0] wslot_i,
  input  logic [NUM_CH-1:0] expire_i,
  output logic [NUM_CH-1:0] ie_o,
  output logic [NUM_CH-1:0] sta_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] start_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ie_q, sta_q, en_q, clr;
  logic              irq_q;

  assign start_o = {NUM_CH{en_we_i}} & wslot_i & ~en_q;
  assign clr     = {NUM_CH{sta_we_i}} & wslot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= '0;
      en_q  <= '0;
      sta_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ie_we_i) ie_q <= wslot_i;
      if (en_we_i) en_q <= wslot_i;
      // a new expiry wins over a same-cycle clear
      sta_q <= (sta_q & ~clr) | expire_i;
      irq_q <= |(sta_q & ie_q);
    end
  end

  assign ie_o  = ie_q;
  assign sta_o = sta_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_en_i,
  output logic              irq_o
);
  logic              hit_ie, hit_sta, hit_en;
  logic [NUM_CH-1:0] hit_ctrl, hit_reld, hit_cnt;
  logic [NUM_CH-1:0] wslot, ie, sta, en, start, expire;
  logic [NUM_CH-1:0][3:0]       ctrl_rd;
  logic [NUM_CH-1:0][CNT_W-1:0] reload, cnt;

  assign hit_ie  = (addr_i == ADDR_W'(A_IE));
  assign hit_sta = (addr_i == ADDR_W'(A_STA));
  assign hit_en  = (addr_i == ADDR_W'(A_EN));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned BASE = A_CH_BASE + CH_STRIDE * i;
    assign wslot[i]    = wdata_i[SLOT_W*i];
    assign hit_ctrl[i] = (addr_i == ADDR_W'(BASE + OFF_CTRL));
    assign hit_reld[i] = (addr_i == ADDR_W'(BASE + OFF_RELD));
    assign hit_cnt[i]  = (addr_i == ADDR_W'(BASE + OFF_CNT));

    pit_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (we_i & hit_ctrl[i]),
      .reld_we_i (we_i & hit_reld[i]),
      .wdata_i   (wdata_i),
      .en_i      (en[i]),
      .start_i   (start[i]),
      .tick_en_i (tick_en_i),
      .ctrl_o    (ctrl_rd[i]),
      .reload_o  (reload[i]),
      .cnt_o     (cnt[i]),
      .expire_o  (expire[i])
    );
  end

  pit_glb_regs #(.NUM_CH(NUM_CH)) u_glb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ie_we_i  (we_i & hit_ie),
    .sta_we_i (we_i & hit_sta),
    .en_we_i  (we_i & hit_en),
    .wslot_i  (wslot),
    .expire_i (expire),
    .ie_o     (ie),
    .sta_o    (sta),
    .en_o     (en),
    .start_o  (start),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_ID))  rdata_o = DATA_W'(ID_VALUE);
    if (addr_i == ADDR_W'(A_CFG)) rdata_o = DATA_W'(NUM_CH);
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_ie)      rdata_o[SLOT_W*i] = ie[i];
      if (hit_sta)     rdata_o[SLOT_W*i] = sta[i];
      if (hit_en)      rdata_o[SLOT_W*i] = en[i];
      if (hit_ctrl[i]) rdata_o = DATA_W'(ctrl_rd[i]);
      if (hit_reld[i]) rdata_o = DATA_W'(reload[i]);
      if (hit_cnt[i])  rdata_o = DATA_W'(cnt[i]);
    end
  end
endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         irq_o,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            wdata_i,
  input logic [NUM_CH-1:0]            ie_i,
  input logic [NUM_CH-1:0]            sta_i,
  input logic [NUM_CH-1:0]            en_i,
  input logic [NUM_CH-1:0]            expire_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload_i
);
  // R7
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(sta_i & ie_i)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5
    sta_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sta_i[i]) |-> $past(expire_i[i]));
    // R6
    sta_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sta_i[i]) |-> $past(we_i && addr_i == ADDR_W'(A_STA) && wdata_i[SLOT_W*i]));
    // R4
    reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(expire_i[i]) |-> cnt_i[i] == $past(reload_i[i]));
    // R8
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[i] && $past(!en_i[i])) |-> $stable(cnt_i[i]));
  end
endmodule

bind pit_timer pit_timer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .ie_i     (ie),
  .sta_i    (sta),
  .en_i     (en),
  .expire_i (expire),
  .cnt_i    (cnt),
  .reload_i (reload)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_en = 1'b0;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  pit_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .tick_en_i(tick_en), .irq_o(irq)
  );

  localparam logic [7:0] T_ID = 8'h00, T_CFG = 8'h10, T_IE = 8'h14,
                         T_STA = 8'h18, T_EN = 8'h1C;

  function automatic logic [7:0] a_ctrl(int c); return 8'h20 + 8'(16*c); endfunction
  function automatic logic [7:0] a_reld(int c); return 8'h24 + 8'(16*c); endfunction
  function automatic logic [7:0] a_cnt(int c);  return 8'h28 + 8'(16*c); endfunction
  function automatic logic [31:0] slot(int c);  return 32'h1 << (4*c); endfunction

  typedef struct packed {
    logic [1:0]  ch;
    logic        src;
    logic [7:0]  rld;
    logic [15:0] cyc;
  } vec_t;
  localparam int NV = 6;
  // channel, bus-clock source, reload, edges from enable to first status
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 8'd3, 16'd4},
    '{2'd1, 1'b1, 8'd0, 16'd1},
    '{2'd2, 1'b0, 8'd2, 16'd6},
    '{2'd3, 1'b1, 8'd9, 16'd10},
    '{2'd0, 1'b0, 8'd0, 16'd2},
    '{2'd3, 1'b0, 8'd5, 16'd12}
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #0.2;
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #0.2;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #0.2;

    // R2 reset state
    chk("R2 irq", {31'd0, irq}, 32'd0);
    rd(T_IE, d);  chk("R2 ie", d, 32'd0);
    rd(T_STA, d); chk("R2 sta", d, 32'd0);
    rd(T_EN, d);  chk("R2 en", d, 32'd0);
    for (int c = 0; c < 4; c++) begin
      rd(a_ctrl(c), d); chk("R2 ctrl", d, 32'd0);
      rd(a_reld(c), d); chk("R2 reld", d, 32'd0);
      rd(a_cnt(c), d);  chk("R2 cnt", d, 32'd0);
    end
    // R1 fixed words
    rd(T_ID, d);  chk("R1 id", d, 32'h7130_0102);
    rd(T_CFG, d); chk("R1 cfg", d, 32'd4);
    // R3 slot bits only
    wr(T_IE, 32'hFFFF_FFFF);
    rd(T_IE, d); chk("R3 ie slots", d, 32'h0000_1111);
    wr(T_IE, 32'h0);

    // R4 R10 vector table
    for (int vi = 0; vi < NV; vi++) begin
      int ch, n;
      ch = int'(VEC[vi].ch);
      n = 0;
      wr(a_ctrl(ch), VEC[vi].src ? 32'h9 : 32'h1);
      wr(a_reld(ch), 32'(VEC[vi].rld));
      wr(T_STA, 32'hFFFF_FFFF);
      wr(T_EN, slot(ch));
      for (int k = 1; k <= 64 && n == 0; k++) begin
        @(negedge clk);
        tick_en = (k % 2 == 0);
        addr = T_STA;
        @(posedge clk);
        #0.2;
        if (rdata[4*ch]) n = k;
      end
      chk("R4 R10 period", 32'(n), 32'(VEC[vi].cyc));
      tick_en = 1'b0;
      wr(T_EN, 32'h0);
      wr(T_STA, 32'hFFFF_FFFF);
    end

    // R4 count readback, R8 freeze and restart
    wr(a_ctrl(1), 32'h9);
    wr(a_reld(1), 32'd10);
    wr(T_EN, slot(1));
    repeat (3) @(posedge clk);
    rd(a_cnt(1), d); chk("R4 count down", d, 32'd7);
    wr(T_EN, 32'h0);
    repeat (5) @(posedge clk);
    rd(a_cnt(1), d); chk("R8 frozen", d, 32'd6);
    wr(T_EN, slot(1));
    rd(a_cnt(1), d); chk("R8 restart", d, 32'd10);
    wr(T_EN, 32'h0);

    // R11 mode bit clear: no counting
    wr(a_ctrl(2), 32'h8);
    wr(a_reld(2), 32'd3);
    wr(T_EN, slot(2));
    repeat (6) @(posedge clk);
    rd(a_cnt(2), d); chk("R11 held", d, 32'd3);
    rd(T_STA, d);    chk("R11 no expiry", d, 32'd0);
    wr(T_EN, 32'h0);

    // R5 R7 R6 status, enable and irq timing
    wr(a_ctrl(0), 32'h9);
    wr(a_reld(0), 32'd2);
    wr(T_EN, slot(0));
    repeat (3) @(posedge clk);
    rd(T_STA, d); chk("R5 set without ie", d, 32'h1);
    chk("R7 masked", {31'd0, irq}, 32'd0);
    wr(T_IE, 32'h1);
    chk("R7 not yet", {31'd0, irq}, 32'd0);
    @(posedge clk); #0.2;
    chk("R7 raised", {31'd0, irq}, 32'd1);
    wr(T_STA, 32'h0);
    rd(T_STA, d); chk("R6 zero keeps", d, 32'h1);
    wr(T_EN, 32'h0);
    wr(T_STA, 32'h1);
    rd(T_STA, d); chk("R6 one clears", d, 32'h0);
    @(posedge clk); #0.2;
    chk("R7 dropped", {31'd0, irq}, 32'd0);
    wr(T_IE, 32'h0);

    // R9 reload write mid-period
    wr(a_ctrl(3), 32'h9);
    wr(a_reld(3), 32'd4);
    wr(T_EN, slot(3));
    @(posedge clk);
    wr(a_reld(3), 32'd9);
    repeat (2) @(posedge clk);
    rd(a_cnt(3), d); chk("R9 old period kept", d, 32'd0);
    rd(T_STA, d);    chk("R9 not early", d, 32'h0);
    @(posedge clk);
    rd(a_cnt(3), d); chk("R9 new reload", d, 32'd9);
    rd(T_STA, d);    chk("R9 expiry", d, 32'h1000);
    wr(T_EN, 32'h0);
    wr(T_STA, 32'hFFFF_FFFF);

    // R13 expiry and clear on the same edge
    wr(a_ctrl(0), 32'h9);
    wr(a_reld(0), 32'd4);
    wr(T_EN, slot(0));
    repeat (4) @(posedge clk);
    wr(T_STA, 32'h1);
    rd(T_STA, d); chk("R13 set wins", d, 32'h1);
    wr(T_EN, 32'h0);
    wr(T_STA, 32'hFFFF_FFFF);
    rd(T_STA, d); chk("R13 cleared after", d, 32'h0);

    // R12 read-only count, unmapped space
    rd(a_cnt(0), v);
    wr(a_cnt(0), 32'h55AA_1234);
    rd(a_cnt(0), d); chk("R12 count read-only", d, v);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, d); chk("R12 gap", d, 32'h0);
    rd(8'h04, d); chk("R12 low hole", d, 32'h0);
    rd(8'h60, d); chk("R12 above map", d, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule